// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the per-channel interrupt causes of a multi-channel DMA engine into a single active-high interrupt line for the host processor. Each channel supplies three signals: a request strobe, a busy flag that is high while the channel is pending or in service, and a one-cycle completion pulse. A request that lands on a channel that is already busy counts as an event error. The error is recorded in a per-channel error register. If the channel's error-enable bit is set, the error also raises that channel's interrupt status bit.

A completion always sets the channel's status bit, whatever the error-enable register holds. An enabled error sets the same status bit. Software therefore cannot tell the two causes apart from the status register alone and must inspect the error register. Reading the error register returns its contents and then empties it. The status and error registers can also be cleared by writing ones to them. An error does not stop the channel; this block only observes the request path.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After synchronous reset the status, error and enable registers read as zero and `irq` is low.
- R2: A channel's error bit is set on the clock edge where its request and busy inputs are both high. A request while not busy sets nothing.
- R3: A new error on a channel whose enable bit is 1 sets that channel's status bit on the same edge.
- R4: A completion pulse sets the channel's status bit whatever the enable register holds.
- R5: An error on a channel whose enable bit is 0 is recorded in the error register but leaves the status bit and `irq` untouched.
- R6: `irq` is registered and equals, one cycle later, the OR of all status bits.
- R7: Writing the status register (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R8: Writing the error register (address 1) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: When a set condition and a clear hit the same bit on the same edge, the bit ends set.
- R10: A read of the error register returns its contents and clears it on the same edge, except for bits newly set on that edge.
- R11: The enable register (address 2) is read/write. Address 3 reads as zero and ignores writes.
- R12: Read data is registered: it shows the addressed register's value from before the read edge, one cycle after the read is presented, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NUM_CH | Per-channel request strobe |
| ch_busy | input | NUM_CH | Per-channel pending/in-service flag |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 status, 1 error, 2 enable, 3 none |
| bus_wdata | input | NUM_CH | Write data |
| bus_rdata | output | NUM_CH | Registered read data |
| irq | output | 1 | Combined host interrupt, active high |

## Verification
The bench drives sparse random requests against random busy flags, so that errors arise on enabled and disabled channels alike. This separates the error-gated path from the completion path, which must ignore the enable bits. Random bus traffic mixes reads, write-one-to-clear bursts and enable updates. It often lands in the same cycle as set conditions, which tests set-over-clear priority and the clear-on-read of the error register. Directed cases isolate a completion with all enables off, a disabled-channel error, a set racing a clear, and the unused address.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int DEF_NUM_CH = 32;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ERROR  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_VOID   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rd_status;
        logic rd_error;
        logic rd_enable;
        logic wr_status;
        logic wr_error;
        logic wr_enable;
    } bus_strobe_t;

    function automatic bus_strobe_t decode_access(logic sel, logic wr, reg_sel_e a);
        bus_strobe_t s;
        s = '0;
        if (sel) begin
            s.rd_status = !wr && (a == SEL_STATUS);
            s.rd_error  = !wr && (a == SEL_ERROR);
            s.rd_enable = !wr && (a == SEL_ENABLE);
            s.wr_status =  wr && (a == SEL_STATUS);
            s.wr_error  =  wr && (a == SEL_ERROR);
            s.wr_enable =  wr && (a == SEL_ENABLE);
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_err_detect.sv
module irq_err_detect #(
    parameter int NUM_CH = dma_irq_pkg::DEF_NUM_CH
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] busy,
    output logic [NUM_CH-1:0] hit
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb hit[c] = req[c] & busy[c];
    end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank #(
    parameter int NUM_CH = dma_irq_pkg::DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] done,
    input  logic              wr_status,
    input  logic              wr_error,
    input  logic              wr_enable,
    input  logic              rd_error,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] status_q,
    output logic [NUM_CH-1:0] error_q,
    output logic [NUM_CH-1:0] enable_q
);
    logic [NUM_CH-1:0] status_clr, error_clr, status_set;

    always_comb begin
        status_clr = wr_status ? wdata : '0;
        error_clr  = rd_error ? '1 : (wr_error ? wdata : '0);
        status_set = done | (hit & enable_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            error_q  <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~status_clr) | status_set;
            error_q  <= (error_q & ~error_clr) | hit;
            if (wr_enable) enable_q <= wdata;
        end
    end

    p_err_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((error_q & $past(hit)) == $past(hit)));

    p_enabled_err_r3: assert property (@(posedge clk) disable iff (rst)
        ((hit & enable_q) != '0) |=> ((status_q & $past(hit & enable_q)) == $past(hit & enable_q)));

    p_done_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (done != '0) |=> ((status_q & $past(done)) == $past(done)));

    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        ((hit & ~enable_q & ~done & ~status_q) != '0)
        |=> ((status_q & $past(hit & ~enable_q & ~done & ~status_q)) == '0));

    p_w0_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_status && (status_set == '0)) |=> ((status_q & ~$past(wdata)) == ($past(status_q) & ~$past(wdata))));
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
    parameter int NUM_CH = dma_irq_pkg::DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_status,
    input  logic              rd_error,
    input  logic              rd_enable,
    input  logic              rd_any,
    input  logic [NUM_CH-1:0] status_q,
    input  logic [NUM_CH-1:0] error_q,
    input  logic [NUM_CH-1:0] enable_q,
    output logic [NUM_CH-1:0] rdata
);
    logic [NUM_CH-1:0] mux;

    always_comb begin
        mux = '0;
        if (rd_status) mux = status_q;
        if (rd_error)  mux = error_q;
        if (rd_enable) mux = enable_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (rd_any) rdata <= mux;
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_any |=> $stable(rdata));
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_busy,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    output logic              irq
);
    bus_strobe_t       stb;
    logic [NUM_CH-1:0] hit, status_q, error_q, enable_q;

    always_comb stb = decode_access(bus_sel, bus_wr, reg_sel_e'(bus_addr));

    irq_err_detect #(.NUM_CH(NUM_CH)) i_det (
        .req(ch_req), .busy(ch_busy), .hit(hit)
    );

    irq_reg_bank #(.NUM_CH(NUM_CH)) i_bank (
        .clk(clk), .rst(rst), .hit(hit), .done(ch_done),
        .wr_status(stb.wr_status), .wr_error(stb.wr_error),
        .wr_enable(stb.wr_enable), .rd_error(stb.rd_error),
        .wdata(bus_wdata),
        .status_q(status_q), .error_q(error_q), .enable_q(enable_q)
    );

    irq_read_port #(.NUM_CH(NUM_CH)) i_rd (
        .clk(clk), .rst(rst),
        .rd_status(stb.rd_status), .rd_error(stb.rd_error),
        .rd_enable(stb.rd_enable), .rd_any(bus_sel && !bus_wr),
        .status_q(status_q), .error_q(error_q), .enable_q(enable_q),
        .rdata(bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |status_q;
    end

    p_irq_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|status_q)));

    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        stb.rd_error |=> (error_q == $past(hit)));
endmodule

// File: tb/test_dma_irq_aggregator.sv
module test_dma_irq_aggregator;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] req = '0, busy = '0, done = '0, wdata = '0;
    logic sel = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [N-1:0] rdata;
    logic irq;

    logic [N-1:0] m_stat = '0, m_err = '0, m_en = '0, m_rd = '0;
    logic m_irq = 1'b0;
    int n_run = 0, n_fail = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    dma_irq_aggregator #(.NUM_CH(N)) i_dma_irq_aggregator (
        .clk(clk), .rst(rst), .ch_req(req), .ch_busy(busy), .ch_done(done),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] sel_reg(logic [1:0] a);
        case (a)
            2'd0: return m_stat;
            2'd1: return m_err;
            2'd2: return m_en;
            default: return '0;
        endcase
    endfunction

    // one clock: drive, model update at the edge, compare at negedge
    task automatic cyc(logic [N-1:0] rq, logic [N-1:0] bz, logic [N-1:0] dn,
                       logic s, logic w, logic [1:0] a, logic [N-1:0] wd);
        logic [N-1:0] h, nst, ner, nen;
        logic rd;
        req = rq; busy = bz; done = dn; sel = s; wr = w; addr = a; wdata = wd;
        @(posedge clk);
        h   = rq & bz;
        rd  = s && !w;
        nst = (m_stat & ~((s && w && a == 2'd0) ? wd : '0)) | dn | (h & m_en);
        ner = (rd && a == 2'd1) ? h : ((m_err & ~((s && w && a == 2'd1) ? wd : '0)) | h);
        nen = (s && w && a == 2'd2) ? wd : m_en;
        if (rd) m_rd = sel_reg(a);
        m_irq  = |m_stat;
        m_stat = nst; m_err = ner; m_en = nen;
        @(negedge clk);
        chk("R6 irq", N'(irq), N'(m_irq));
        if (rd) chk(a == 2'd1 ? "R10/R12 read" : "R11/R12 read", rdata, m_rd);
    endtask

    task automatic idle(); cyc('0, '0, '0, 0, 0, 0, '0); endtask
    task automatic rd_reg(logic [1:0] a); cyc('0, '0, '0, 1, 0, a, '0); endtask
    task automatic wr_reg(logic [1:0] a, logic [N-1:0] d); cyc('0, '0, '0, 1, 1, a, d); endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", N'(irq), '0);
        rd_reg(0); chk("R1 status", rdata, '0);
        rd_reg(1); chk("R1 error", rdata, '0);
        rd_reg(2); chk("R1 enable", rdata, '0);

        // R4 done with all enables off
        cyc('0, '0, 32'h0000_0010, 0, 0, 0, '0);
        idle(); chk("R4 irq after done", N'(irq), 1);
        rd_reg(0); chk("R4 status", rdata, 32'h0000_0010);
        wr_reg(0, 32'h0000_0010); idle();
        rd_reg(0); chk("R7 cleared", rdata, '0);

        // R2 request while idle sets nothing; R5 disabled error
        cyc(32'h1, 32'h0, '0, 0, 0, 0, '0);
        rd_reg(1); chk("R2 idle req", rdata, '0);
        cyc(32'h2, 32'h2, '0, 0, 0, 0, '0);
        idle(); chk("R5 irq low", N'(irq), 0);
        rd_reg(0); chk("R5 status", rdata, '0);
        rd_reg(1); chk("R2 error bit", rdata, 32'h2);
        rd_reg(1); chk("R10 cleared by read", rdata, '0);

        // R3 enabled error
        wr_reg(2, 32'h8000_0004);
        rd_reg(2); chk("R11 enable", rdata, 32'h8000_0004);
        cyc(32'h8000_0000, 32'h8000_0000, '0, 0, 0, 0, '0);
        idle(); chk("R3 irq", N'(irq), 1);
        rd_reg(0); chk("R3 status", rdata, 32'h8000_0000);

        // R9 set races clear on status and error
        cyc(32'h4, 32'h4, '0, 1, 1, 0, 32'h8000_0004);
        rd_reg(0); chk("R9 status", rdata, 32'h4);
        cyc(32'h4, 32'h4, '0, 1, 1, 1, 32'hFFFF_FFFF);
        rd_reg(1); chk("R9 error", rdata, 32'h4);
        // R8 W1C on error, zeros kept
        cyc(32'h30, 32'h30, '0, 0, 0, 0, '0);
        wr_reg(1, 32'h10);
        rd_reg(1); chk("R8 error", rdata, 32'h20);
        // R11 unused address
        wr_reg(3, 32'hFFFF_FFFF);
        rd_reg(3); chk("R11 addr3", rdata, '0);
        rd_reg(2); chk("R11 enable kept", rdata, 32'h8000_0004);
        // R12 hold without read
        idle(); chk("R12 hold", rdata, 32'h8000_0004);
        wr_reg(0, '1); wr_reg(1, '1); idle();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] rq, bz, dn, wd;
            logic s, w;
            logic [1:0] a;
            rq = $urandom & $urandom & $urandom;
            bz = $urandom;
            dn = $urandom & $urandom & $urandom & $urandom & $urandom;
            s  = ($urandom % 3) != 0;
            w  = $urandom % 2;
            a  = 2'($urandom % 4);
            wd = (a == 2'd2) ? ($urandom & $urandom) : $urandom;
            cyc(rq, bz, dn, s, w, a, wd);
        end
        for (int a = 0; a < 3; a++) rd_reg(2'(a));

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule